// File: doc/BRIEF.md
# Counter-Based Register Window Spill/Fill Controller

This block keeps the window bookkeeping for a processor whose register file is organised as a ring of overlapping windows. It tracks five things: the current window pointer, the number of windows that may still be saved, the number that may be restored, the number held by another context, and the number of windows known to be clean. It takes one operation per cycle on a 3-bit opcode: save, restore, flush, saved, restored, pointer write and other-context write. A save or restore that the counters cannot satisfy does not change any state. Instead it produces a one-cycle trap pulse with a 9-bit trap type, and the caller uses that type to pick the spill or fill handler.

The number of implemented windows `nwin` is an input, so it can be chosen at run time. It must stay stable between resets, and every bound the block uses is derived from it. The window-state input `wstate` selects the handler sub-vector. Its high three bits are used when windows belong to another context, and its low three bits are used otherwise. All outputs are registered, so the result of an operation is visible one clock after it is presented.

Top module: `wsf_ctrl`

## Requirements
- R1: After a synchronous reset: `cansave` = `cleanwin` = nwin-2, `canrestore` = 0, `otherwin` = 0, `cwp_ext` = nwin-1, `trap_valid` = 0 and `trap_type` = 0.
- R2: Save (op 1) with `cansave` != 0: `cansave` decreases by 1 and `canrestore` increases by 1. The reported pointer `cwp_ext` goes up by 1 and wraps from nwin-1 to 0.
- R3: Restore (op 2) with `canrestore` != 0: `canrestore` decreases by 1 and `cansave` increases by 1. `cwp_ext` goes down by 1 and wraps from 0 to nwin-1.
- R4: Save with `cansave` = 0 raises a spill trap (base 0x080) and leaves every counter and `cwp_ext` unchanged.
- R5: Restore with `canrestore` = 0 raises a fill trap (base 0x0C0) and leaves every counter and `cwp_ext` unchanged.
- R6: The trap type is the base ORed with a sub-vector. If `otherwin` != 0, the sub-vector is 0x020 ORed with `wstate`[5:3] placed in bits 4:2. Otherwise it is `wstate`[2:0] placed in bits 4:2.
- R7: Flush (op 3) raises a spill trap when `cansave` != nwin-2, and does nothing when `cansave` = nwin-2. In both cases no counter changes.
- R8: Saved (op 4) increases `cansave` by 1. It then decreases `otherwin` if that is non-zero; otherwise it decreases `canrestore`.
- R9: Restored (op 5) increases `canrestore` by 1 and increases `cleanwin` only while `cleanwin` < nwin-1. It decreases `cansave` only when `otherwin` = 0.
- R10: Pointer write (op 6) makes `cwp_ext` equal to `op_data`. A value of nwin or more is taken as 0.
- R11: Other-context write (op 7) loads `otherwin` from `op_data`.
- R12: `trap_valid` is high for exactly the one cycle after a trapping operation. `trap_type` is 0 whenever `trap_valid` is low, and idle (op 0) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nwin | input | NWW (6) | Number of implemented windows, 3..MAX_WIN |
| wstate | input | 6 | Window state; [5:3] selects the other-context handler, [2:0] the normal one |
| op | input | 3 | Operation: 0 idle, 1 save, 2 restore, 3 flush, 4 saved, 5 restored, 6 pointer write, 7 other-context write |
| op_data | input | CW (5) | Operand for ops 6 and 7 |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_type | output | 9 | Trap type; 0 when no trap |
| cwp_ext | output | CW (5) | Reported window pointer (nwin-1 minus the internal pointer) |
| cansave | output | CW (5) | Windows that can be saved |
| canrestore | output | CW (5) | Windows that can be restored |
| otherwin | output | CW (5) | Windows owned by another context |
| cleanwin | output | CW (5) | Clean windows |

## Verification
The save and restore paths are driven through both pointer wraps and until the counters reach zero. This separates a correct modulo-nwin wrap from a power-of-two mask, and a trapping operation from one that goes ahead. Flush is tried both with `cansave` at nwin-2 and away from it. Saved and restored are each tried with `otherwin` zero and non-zero, so that the counter each one moves is distinguished, and restored is repeated past the `cleanwin` ceiling. Two different `wstate` values and both `otherwin` states are used, so that the high and low selector fields and the 0x020 flag are told apart in the trap type. A second reset with nwin=5 shows that every bound follows the run-time window count.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_SAVE     = 3'd1,
    OP_RESTORE  = 3'd2,
    OP_FLUSH    = 3'd3,
    OP_SAVED    = 3'd4,
    OP_RESTORED = 3'd5,
    OP_WRCWP    = 3'd6,
    OP_WROTHER  = 3'd7
  } wsf_op_e;

  localparam logic [8:0] SPILL_BASE = 9'h080;
  localparam logic [8:0] FILL_BASE  = 9'h0C0;
  localparam logic [8:0] OTHER_FLAG = 9'h020;

  // sub-vector: selector field placed in bits 4:2
  function automatic logic [8:0] sub_vector(input logic other, input logic [5:0] ws);
    logic [8:0] v;
    if (other) v = OTHER_FLAG | {4'd0, ws[5:3], 2'd0};
    else       v = {4'd0, ws[2:0], 2'd0};
    return v;
  endfunction
endpackage

// File: rtl/wsf_cwp_unit.sv
module wsf_cwp_unit #(
  parameter int MAX_WIN = 32,
  localparam int CW  = $clog2(MAX_WIN),
  localparam int NWW = $clog2(MAX_WIN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NWW-1:0] nwin,
  input  logic           dec,
  input  logic           inc,
  input  logic           wr,
  input  logic [CW-1:0]  wr_val,
  output logic [CW-1:0]  cwp_ext
);
  logic [NWW-1:0] last;
  logic [CW-1:0]  cwp_q, cwp_d;

  assign last = nwin - NWW'(1);

  always_comb begin
    cwp_d = cwp_q;
    if (dec) begin
      cwp_d = (cwp_q == '0) ? CW'(last) : cwp_q - CW'(1);
    end else if (inc) begin
      cwp_d = ({1'b0, cwp_q} == NWW'(last)) ? '0 : cwp_q + CW'(1);
    end else if (wr) begin
      // external value out of range is taken as zero
      if ({1'b0, wr_val} >= nwin) cwp_d = CW'(last);
      else                        cwp_d = CW'(last - {1'b0, wr_val});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q   <= '0;
      cwp_ext <= CW'(last);
    end else begin
      cwp_q   <= cwp_d;
      cwp_ext <= CW'(last - {1'b0, cwp_d});
    end
  end
endmodule

// File: rtl/wsf_win_counters.sv
module wsf_win_counters #(
  parameter int MAX_WIN = 32,
  localparam int CW  = $clog2(MAX_WIN),
  localparam int NWW = $clog2(MAX_WIN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NWW-1:0] nwin,
  input  logic           do_save,
  input  logic           do_restore,
  input  logic           do_saved,
  input  logic           do_restored,
  input  logic           do_wrother,
  input  logic [CW-1:0]  wr_val,
  output logic [CW-1:0]  cansave,
  output logic [CW-1:0]  canrestore,
  output logic [CW-1:0]  otherwin,
  output logic [CW-1:0]  cleanwin
);
  logic [CW-1:0] cs_d, cr_d, ow_d, cw_d;
  logic          ow_zero, clean_room;

  assign ow_zero    = (otherwin == '0);
  assign clean_room = ({1'b0, cleanwin} < (nwin - NWW'(1)));

  always_comb begin
    cs_d = cansave;
    cr_d = canrestore;
    ow_d = otherwin;
    cw_d = cleanwin;
    if (do_save) begin
      cs_d = cansave - CW'(1);
      cr_d = canrestore + CW'(1);
    end else if (do_restore) begin
      cs_d = cansave + CW'(1);
      cr_d = canrestore - CW'(1);
    end else if (do_saved) begin
      cs_d = cansave + CW'(1);
      if (!ow_zero) ow_d = otherwin - CW'(1);
      else          cr_d = canrestore - CW'(1);
    end else if (do_restored) begin
      cr_d = canrestore + CW'(1);
      if (clean_room) cw_d = cleanwin + CW'(1);
      if (ow_zero)    cs_d = cansave - CW'(1);
    end else if (do_wrother) begin
      ow_d = wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cansave    <= CW'(nwin - NWW'(2));
      cleanwin   <= CW'(nwin - NWW'(2));
      canrestore <= '0;
      otherwin   <= '0;
    end else begin
      cansave    <= cs_d;
      canrestore <= cr_d;
      otherwin   <= ow_d;
      cleanwin   <= cw_d;
    end
  end
endmodule

// File: rtl/wsf_trap_enc.sv
module wsf_trap_enc (
  input  logic       clk,
  input  logic       rst,
  input  logic       spill,
  input  logic       fill,
  input  logic       other,
  input  logic [5:0] wstate,
  output logic       trap_valid,
  output logic [8:0] trap_type
);
  import wsf_pkg::*;
  logic [8:0] type_d;

  always_comb begin
    type_d = '0;
    if (spill)     type_d = SPILL_BASE | sub_vector(other, wstate);
    else if (fill) type_d = FILL_BASE | sub_vector(other, wstate);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_type  <= '0;
    end else begin
      trap_valid <= spill | fill;
      trap_type  <= type_d;
    end
  end
endmodule

// File: rtl/wsf_ctrl.sv
module wsf_ctrl #(
  parameter int MAX_WIN = 32,
  localparam int CW  = $clog2(MAX_WIN),
  localparam int NWW = $clog2(MAX_WIN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NWW-1:0] nwin,
  input  logic [5:0]     wstate,
  input  logic [2:0]     op,
  input  logic [CW-1:0]  op_data,
  output logic           trap_valid,
  output logic [8:0]     trap_type,
  output logic [CW-1:0]  cwp_ext,
  output logic [CW-1:0]  cansave,
  output logic [CW-1:0]  canrestore,
  output logic [CW-1:0]  otherwin,
  output logic [CW-1:0]  cleanwin
);
  import wsf_pkg::*;

  wsf_op_e op_e;
  logic is_save, is_restore, is_flush;
  logic do_save, do_restore, spill, fill;

  assign op_e       = wsf_op_e'(op);
  assign is_save    = (op_e == OP_SAVE);
  assign is_restore = (op_e == OP_RESTORE);
  assign is_flush   = (op_e == OP_FLUSH);

  assign do_save    = is_save && (cansave != '0);
  assign do_restore = is_restore && (canrestore != '0);
  assign spill      = (is_save && (cansave == '0)) ||
                      (is_flush && ({1'b0, cansave} != (nwin - NWW'(2))));
  assign fill       = is_restore && (canrestore == '0);

  wsf_cwp_unit #(.MAX_WIN(MAX_WIN)) u_cwp (
    .clk     (clk),
    .rst     (rst),
    .nwin    (nwin),
    .dec     (do_save),
    .inc     (do_restore),
    .wr      (op_e == OP_WRCWP),
    .wr_val  (op_data),
    .cwp_ext (cwp_ext)
  );

  wsf_win_counters #(.MAX_WIN(MAX_WIN)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .nwin        (nwin),
    .do_save     (do_save),
    .do_restore  (do_restore),
    .do_saved    (op_e == OP_SAVED),
    .do_restored (op_e == OP_RESTORED),
    .do_wrother  (op_e == OP_WROTHER),
    .wr_val      (op_data),
    .cansave     (cansave),
    .canrestore  (canrestore),
    .otherwin    (otherwin),
    .cleanwin    (cleanwin)
  );

  wsf_trap_enc u_trap (
    .clk        (clk),
    .rst        (rst),
    .spill      (spill),
    .fill       (fill),
    .other      (otherwin != '0),
    .wstate     (wstate),
    .trap_valid (trap_valid),
    .trap_type  (trap_type)
  );
endmodule

// File: rtl/wsf_ctrl_chk.sv
module wsf_ctrl_chk #(
  parameter int MAX_WIN = 32,
  localparam int CW  = $clog2(MAX_WIN),
  localparam int NWW = $clog2(MAX_WIN + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic [NWW-1:0] nwin,
  input logic [5:0]     wstate,
  input logic [2:0]     op,
  input logic [CW-1:0]  op_data,
  input logic           trap_valid,
  input logic [8:0]     trap_type,
  input logic [CW-1:0]  cwp_ext,
  input logic [CW-1:0]  cansave,
  input logic [CW-1:0]  canrestore,
  input logic [CW-1:0]  otherwin,
  input logic [CW-1:0]  cleanwin
);
  // R2
  p_save_ok_r2: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1 && cansave != '0) |=>
      (cansave == CW'($past(cansave) - 1) && canrestore == CW'($past(canrestore) + 1)));

  // R3
  p_restore_ok_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 && canrestore != '0) |=>
      (canrestore == CW'($past(canrestore) - 1) && cansave == CW'($past(cansave) + 1)));

  // R4
  p_spill_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1 && cansave == '0) |=>
      (trap_valid && trap_type[8:6] == 3'b010 && $stable(cansave) && $stable(cwp_ext)));

  // R5
  p_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 && canrestore == '0) |=>
      (trap_valid && trap_type[8:6] == 3'b011 && $stable(canrestore) && $stable(cwp_ext)));

  // R7
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd3) |=> ($stable(cansave) && $stable(canrestore) && $stable(otherwin)));

  // R9
  p_clean_cap_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5) |=> ({1'b0, cleanwin} <= nwin - NWW'(1)));

  // R12
  p_idle_no_trap_r12: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0) |=> (!trap_valid && trap_type == 9'd0 && $stable(cansave) && $stable(cwp_ext)));
endmodule

bind wsf_ctrl wsf_ctrl_chk #(.MAX_WIN(MAX_WIN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .nwin       (nwin),
  .wstate     (wstate),
  .op         (op),
  .op_data    (op_data),
  .trap_valid (trap_valid),
  .trap_type  (trap_type),
  .cwp_ext    (cwp_ext),
  .cansave    (cansave),
  .canrestore (canrestore),
  .otherwin   (otherwin),
  .cleanwin   (cleanwin)
);

// File: tb/test_wsf_ctrl.sv
module test_wsf_ctrl;
  localparam int MAX_WIN = 32;
  localparam int CW  = $clog2(MAX_WIN);
  localparam int NWW = $clog2(MAX_WIN + 1);

  logic           clk = 1'b0;
  logic           rst;
  logic [NWW-1:0] nwin;
  logic [5:0]     wstate;
  logic [2:0]     op;
  logic [CW-1:0]  op_data;
  logic           trap_valid;
  logic [8:0]     trap_type;
  logic [CW-1:0]  cwp_ext, cansave, canrestore, otherwin, cleanwin;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wsf_ctrl #(.MAX_WIN(MAX_WIN)) i_wsf_ctrl (
    .clk(clk), .rst(rst), .nwin(nwin), .wstate(wstate), .op(op), .op_data(op_data),
    .trap_valid(trap_valid), .trap_type(trap_type), .cwp_ext(cwp_ext),
    .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin), .cleanwin(cleanwin)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [4:0] dat;
    logic [4:0] cs, cr, ow, cw, ext;
    logic       tv;
    logic [8:0] tt;
  } vec_t;

  // nwin = 8, wstate = 6'b101_011; reset state cs6 cr0 ow0 cw6 ext7
  localparam vec_t TBL [18] = '{
    '{3'd2, 5'd0, 5'd6, 5'd0, 5'd0, 5'd6, 5'd7, 1'b1, 9'h0CC}, // R5 R6 fill
    '{3'd1, 5'd0, 5'd5, 5'd1, 5'd0, 5'd6, 5'd0, 1'b0, 9'h000}, // R2 wrap to 0
    '{3'd1, 5'd0, 5'd4, 5'd2, 5'd0, 5'd6, 5'd1, 1'b0, 9'h000}, // R2
    '{3'd3, 5'd0, 5'd4, 5'd2, 5'd0, 5'd6, 5'd1, 1'b1, 9'h08C}, // R7 flush traps
    '{3'd2, 5'd0, 5'd5, 5'd1, 5'd0, 5'd6, 5'd0, 1'b0, 9'h000}, // R3
    '{3'd2, 5'd0, 5'd6, 5'd0, 5'd0, 5'd6, 5'd7, 1'b0, 9'h000}, // R3 wrap to 7
    '{3'd3, 5'd0, 5'd6, 5'd0, 5'd0, 5'd6, 5'd7, 1'b0, 9'h000}, // R7 no trap
    '{3'd5, 5'd0, 5'd5, 5'd1, 5'd0, 5'd7, 5'd7, 1'b0, 9'h000}, // R9
    '{3'd5, 5'd0, 5'd4, 5'd2, 5'd0, 5'd7, 5'd7, 1'b0, 9'h000}, // R9 clean ceiling
    '{3'd7, 5'd2, 5'd4, 5'd2, 5'd2, 5'd7, 5'd7, 1'b0, 9'h000}, // R11
    '{3'd4, 5'd0, 5'd5, 5'd2, 5'd1, 5'd7, 5'd7, 1'b0, 9'h000}, // R8 other != 0
    '{3'd5, 5'd0, 5'd5, 5'd3, 5'd1, 5'd7, 5'd7, 1'b0, 9'h000}, // R9 other != 0
    '{3'd6, 5'd3, 5'd5, 5'd3, 5'd1, 5'd7, 5'd3, 1'b0, 9'h000}, // R10
    '{3'd6, 5'd9, 5'd5, 5'd3, 5'd1, 5'd7, 5'd0, 1'b0, 9'h000}, // R10 out of range
    '{3'd1, 5'd0, 5'd4, 5'd4, 5'd1, 5'd7, 5'd1, 1'b0, 9'h000}, // R2
    '{3'd3, 5'd0, 5'd4, 5'd4, 5'd1, 5'd7, 5'd1, 1'b1, 9'h0B4}, // R6 R7 other spill
    '{3'd4, 5'd0, 5'd5, 5'd4, 5'd0, 5'd7, 5'd1, 1'b0, 9'h000}, // R8
    '{3'd0, 5'd0, 5'd5, 5'd4, 5'd0, 5'd7, 5'd1, 1'b0, 9'h000}  // R12 idle
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int cs, input int cr, input int ow,
                           input int cw, input int ext, input int tv, input int tt);
    chk({req, " cansave"}, cansave, cs);
    chk({req, " canrestore"}, canrestore, cr);
    chk({req, " otherwin"}, otherwin, ow);
    chk({req, " cleanwin"}, cleanwin, cw);
    chk({req, " cwp_ext"}, cwp_ext, ext);
    chk({req, " trap_valid"}, trap_valid, tv);
    chk({req, " trap_type"}, trap_type, tt);
  endtask

  task automatic apply(input logic [2:0] o, input logic [4:0] d);
    op = o; op_data = d;
    @(negedge clk);
    op = 3'd0; op_data = '0;
  endtask

  task automatic do_reset(input int nw);
    nwin = NWW'(nw); rst = 1'b1; op = 3'd0; op_data = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    wstate = 6'b101_011;
    do_reset(8);
    chk_state("R1 nw8", 6, 0, 0, 6, 7, 0, 0);
    for (int i = 0; i < 18; i++) begin
      op = TBL[i].op; op_data = TBL[i].dat;
      @(negedge clk);
      chk_state($sformatf("R2-R12 vec%0d", i), TBL[i].cs, TBL[i].cr, TBL[i].ow,
                TBL[i].cw, TBL[i].ext, TBL[i].tv, TBL[i].tt);
    end
    op = 3'd0;
    @(negedge clk);
    chk("R12 pulse ends", trap_valid, 0);

    // run-time window count of 5
    do_reset(5);
    chk_state("R1 nw5", 3, 0, 0, 3, 4, 0, 0);
    apply(3'd7, 5'd3);
    apply(3'd2, 5'd0);
    chk_state("R5 R6 other fill", 3, 0, 3, 3, 4, 1, 9'h0F4);
    wstate = 6'b010_110;
    apply(3'd7, 5'd0);
    apply(3'd1, 5'd0);
    apply(3'd1, 5'd0);
    apply(3'd1, 5'd0);
    chk_state("R2 nw5 saves", 0, 3, 0, 3, 2, 0, 0);
    apply(3'd1, 5'd0);
    chk_state("R4 R6 spill", 0, 3, 0, 3, 2, 1, 9'h098);
    apply(3'd6, 5'd5);
    chk("R10 nw5 out of range", cwp_ext, 0);
    apply(3'd6, 5'd4);
    chk("R10 nw5 top", cwp_ext, 4);
    apply(3'd3, 5'd0);
    chk_state("R7 nw5 flush", 0, 3, 0, 3, 4, 1, 9'h098);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule